// File: doc/BRIEF.md
# Radix-16 Iterative Integer Divider

This block divides one 32-bit integer by another, signed or unsigned, and returns either the quotient or the remainder. It is meant to sit beside the execute stage of a small 32-bit processor core. The core starts an operation and waits for the one-cycle completion pulse. Each clock of the iteration phase retires one 4-bit quotient digit. To do this, it shifts the next dividend nibble into a 36-bit window made of the running remainder and that nibble. It then picks the largest of the multiples 1 to 15 of the divisor that does not exceed the window. Those fifteen multiples are formed once at the start of an operation and held in registers.

The unsigned operations go straight into eight digit cycles. The signed operations add one cycle in front, which replaces both operands by their magnitudes. They also add one cycle behind, which restores the sign of the quotient and the remainder by two's complement negation. Division by zero and the signed overflow case give fixed, well-defined answers. These fall out of the digit loop without a separate path.

Top module: `div_r16`

## Requirements
- R1: With `op_i` = 2'b01 (unsigned quotient) or 2'b11 (unsigned remainder), `result_o` at completion is the unsigned quotient or remainder of `dividend_i` by a nonzero `divisor_i`.
- R2: With `op_i` = 2'b00 (signed quotient), the result is the two's complement quotient rounded toward zero. It is negative when exactly one operand is negative.
- R3: With `op_i` = 2'b10 (signed remainder), the result satisfies dividend = quotient*divisor + remainder. It carries the sign of the dividend and its magnitude is below that of the divisor.
- R4: A zero divisor gives a quotient with all bits set, for both signed and unsigned operations. It also gives a remainder equal to the dividend.
- R5: A signed division of -2^31 by -1 gives a quotient of -2^31 and a remainder of 0.
- R6: For an unsigned operation, `done_o` is high exactly 8 clock cycles after the rising edge at which `start_i` was accepted.
- R7: For a signed operation, `done_o` is high exactly 10 clock cycles after the accepting edge.
- R8: After reset, `busy_o`, `done_o` and `result_o` are 0. `busy_o` stays high from the accepting edge until completion. `done_o` is a one-cycle pulse with `busy_o` low. `result_o` holds its value until the next completion.
- R9: `start_i` is ignored while `busy_o` is high: neither the result nor the completion cycle of the running operation changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation; accepted only while idle |
| op_i | input | 2 | bit 0: 1 = unsigned, 0 = signed; bit 1: 1 = remainder, 0 = quotient |
| dividend_i | input | 32 | Dividend, sampled at the accepting edge |
| divisor_i | input | 32 | Divisor, sampled at the accepting edge |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse: `result_o` has just been updated |
| result_o | output | 32 | Quotient or remainder of the last finished operation |

## Verification
The bench sweeps every pairing of sixteen corner operands: zero, one, small values, the unsigned maximum, the signed minimum and its neighbours, and negative divisors. It runs each pairing through all four operations, then runs a long stream of random operands. Expected results come from magnitude arithmetic in the bench. A faulty sign fix-up shows up as a wrong sign on mixed-sign pairs. So does a remainder that takes the divisor's sign. A zero-divisor quotient that passes through the negation comes out as 1 instead of all ones. A digit choice that stops at the wrong multiple leaves a remainder at or above the divisor. Off-by-one iteration counts, and restarts taken while busy, move the completion pulse or corrupt the result; the latency and injected-start checks catch both.

// File: rtl/div_r16_pkg.sv
package div_r16_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PRE  = 2'd1,
      ST_ITER = 2'd2,
      ST_POST = 2'd3
   } div_state_e;

endpackage

// File: rtl/div_multiples.sv
// Forms k * divisor for k = 1 .. 2**DIGIT_W - 1, widened by DIGIT_W bits.
module div_multiples #(
   parameter int XLEN        = 32,
   parameter int DIGIT_W     = 4,
   parameter bit ADDER_CHAIN = 1'b1,
   localparam int NMULT      = (1 << DIGIT_W) - 1,
   localparam int WIN_W      = XLEN + DIGIT_W
) (
   input  logic [XLEN-1:0]             divisor_i,
   output logic [NMULT:1][WIN_W-1:0]   mult_o
);

   logic [WIN_W-1:0] base;
   assign base = {{DIGIT_W{1'b0}}, divisor_i};

   if (ADDER_CHAIN) begin : g_chain
      assign mult_o[1] = base;
      for (genvar k = 2; k <= NMULT; k++) begin : g_step
         assign mult_o[k] = mult_o[k-1] + base;
      end
   end else begin : g_mul
      for (genvar k = 1; k <= NMULT; k++) begin : g_prod
         assign mult_o[k] = WIN_W'(k) * base;
      end
   end

endmodule

// File: rtl/div_digit_sel.sv
// Priority search from the largest multiple down; the first one that fits
// the window gives the digit and the difference.
module div_digit_sel #(
   parameter int XLEN    = 32,
   parameter int DIGIT_W = 4,
   localparam int NMULT  = (1 << DIGIT_W) - 1,
   localparam int WIN_W  = XLEN + DIGIT_W
) (
   input  logic [WIN_W-1:0]            win_i,
   input  logic [NMULT:1][WIN_W-1:0]   mult_i,
   output logic [DIGIT_W-1:0]          digit_o,
   output logic [WIN_W-1:0]            diff_o
);

   logic             hit;
   logic [WIN_W-1:0] sub;

   always_comb begin
      hit     = 1'b0;
      sub     = '0;
      digit_o = '0;
      for (int k = NMULT; k >= 1; k--) begin
         if (!hit && (win_i >= mult_i[k])) begin
            hit     = 1'b1;
            sub     = mult_i[k];
            digit_o = DIGIT_W'(k);
         end
      end
      diff_o = win_i - sub;
   end

endmodule

// File: rtl/div_r16.sv
module div_r16
   import div_r16_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int DIGIT_W     = 4,
   parameter bit ADDER_CHAIN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [1:0]       op_i,
   input  logic [XLEN-1:0]  dividend_i,
   input  logic [XLEN-1:0]  divisor_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [XLEN-1:0]  result_o
);

   localparam int NMULT = (1 << DIGIT_W) - 1;
   localparam int WIN_W = XLEN + DIGIT_W;
   localparam int ITERS = XLEN / DIGIT_W;
   localparam int CNT_W = $clog2(ITERS);
   localparam int LAT_W = $clog2(ITERS + 4) + 1;

   if (XLEN % DIGIT_W != 0) begin : g_bad_split
      $error("XLEN must be a multiple of DIGIT_W");
   end
   if (ITERS < 2) begin : g_bad_iters
      $error("at least two digit cycles are required");
   end
   if (DIGIT_W < 1 || DIGIT_W > 6) begin : g_bad_digit
      $error("DIGIT_W out of supported range 1..6");
   end

   div_state_e state_q;
   logic [CNT_W-1:0]          cnt_q;
   logic                      signed_q, is_rem_q, neg_quo_q, neg_rem_q, dz_q;
   logic [XLEN-1:0]           a_q, b_q, quo_q, rem_q, result_q;
   logic [NMULT:1][WIN_W-1:0] mult_q, mult_nx;
   logic                      done_q;

   logic [XLEN-1:0]    a_mag, b_mag, mult_src, quo_next, rem_next;
   logic [WIN_W-1:0]   win, diff;
   logic [DIGIT_W-1:0] digit;
   logic               last;

   assign a_mag    = a_q[XLEN-1] ? (~a_q + XLEN'(1)) : a_q;
   assign b_mag    = b_q[XLEN-1] ? (~b_q + XLEN'(1)) : b_q;
   assign mult_src = (state_q == ST_PRE) ? b_mag : divisor_i;

   div_multiples #(
      .XLEN(XLEN), .DIGIT_W(DIGIT_W), .ADDER_CHAIN(ADDER_CHAIN)
   ) u_mult (
      .divisor_i(mult_src),
      .mult_o   (mult_nx)
   );

   assign win = {rem_q, quo_q[XLEN-1 -: DIGIT_W]};

   div_digit_sel #(
      .XLEN(XLEN), .DIGIT_W(DIGIT_W)
   ) u_sel (
      .win_i  (win),
      .mult_i (mult_q),
      .digit_o(digit),
      .diff_o (diff)
   );

   assign quo_next = {quo_q[XLEN-DIGIT_W-1:0], digit};
   assign rem_next = diff[XLEN-1:0];
   assign last     = (cnt_q == CNT_W'(ITERS - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         signed_q  <= 1'b0;
         is_rem_q  <= 1'b0;
         neg_quo_q <= 1'b0;
         neg_rem_q <= 1'b0;
         dz_q      <= 1'b0;
         a_q       <= '0;
         b_q       <= '0;
         quo_q     <= '0;
         rem_q     <= '0;
         mult_q    <= '0;
         result_q  <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  a_q       <= dividend_i;
                  b_q       <= divisor_i;
                  is_rem_q  <= op_i[1];
                  signed_q  <= !op_i[0];
                  dz_q      <= (divisor_i == '0);
                  neg_quo_q <= !op_i[0] && (divisor_i != '0) &&
                               (dividend_i[XLEN-1] ^ divisor_i[XLEN-1]);
                  neg_rem_q <= !op_i[0] && dividend_i[XLEN-1];
                  cnt_q     <= '0;
                  if (op_i[0]) begin
                     quo_q   <= dividend_i;
                     rem_q   <= '0;
                     mult_q  <= mult_nx;
                     state_q <= ST_ITER;
                  end else begin
                     state_q <= ST_PRE;
                  end
               end
            end
            ST_PRE: begin
               quo_q   <= a_mag;
               rem_q   <= '0;
               mult_q  <= mult_nx;
               state_q <= ST_ITER;
            end
            ST_ITER: begin
               quo_q <= quo_next;
               rem_q <= rem_next;
               cnt_q <= cnt_q + CNT_W'(1);
               if (last) begin
                  if (signed_q) begin
                     state_q <= ST_POST;
                  end else begin
                     result_q <= is_rem_q ? rem_next : quo_next;
                     done_q   <= 1'b1;
                     state_q  <= ST_IDLE;
                  end
               end
            end
            ST_POST: begin
               if (is_rem_q) result_q <= neg_rem_q ? (~rem_q + XLEN'(1)) : rem_q;
               else          result_q <= neg_quo_q ? (~quo_q + XLEN'(1)) : quo_q;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o   = (state_q != ST_IDLE);
   assign done_o   = done_q;
   assign result_o = result_q;

   // cycles since the accepting edge, for the latency checks
   logic [LAT_W-1:0] lat_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         lat_q <= '0;
      else if (state_q == ST_IDLE && start_i) lat_q <= LAT_W'(1);
      else if (busy_o)                     lat_q <= lat_q + LAT_W'(1);
   end

   // R1: each digit step leaves a partial remainder below the divisor
   assert_rem_below_divisor_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_ITER && !dz_q) |->
         (diff[WIN_W-1:XLEN] == '0 && {{DIGIT_W{1'b0}}, rem_next} < mult_q[1]));

   // R4: zero divisor quotient has every bit set
   assert_divzero_quot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && dz_q && !is_rem_q) |-> (result_o == '1));

   // R6 / R7: completion cycle depends only on signedness
   assert_latency_R6_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (lat_q == (signed_q ? LAT_W'(ITERS + 3) : LAT_W'(ITERS + 1))));

   // R8: completion is a single pulse, with the unit already idle
   assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);
   assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);

   // R9: a start during the digit loop does not disturb the step count
   assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_ITER && start_i && !last) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: tb/div_r16_tb.sv
`timescale 1ns/1ps
module div_r16_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [31:0] a = '0;
   logic [31:0] b = '0;
   logic        busy, done;
   logic [31:0] res;

   int total = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   div_r16 #(.XLEN(32), .DIGIT_W(4), .ADDER_CHAIN(1'b1)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
      .dividend_i(a), .divisor_i(b),
      .busy_o(busy), .done_o(done), .result_o(res)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model(input logic [1:0] o, input logic [31:0] x,
                                         input logic [31:0] y);
      logic sg, xn, yn;
      logic [31:0] xm, ym, q, r;
      sg = !o[0];
      xn = sg && x[31];
      yn = sg && y[31];
      xm = xn ? -x : x;
      ym = yn ? -y : y;
      if (ym == 0) begin q = '1; r = xm; end
      else begin q = xm / ym; r = xm % ym; end
      if (y != 0 && (xn ^ yn)) q = -q;
      if (xn) r = -r;
      return o[1] ? r : q;
   endfunction

   function automatic string tag_of(input logic [1:0] o, input logic [31:0] x,
                                    input logic [31:0] y);
      if (y == 0) return "R4";
      if (!o[0] && x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return "R5";
      if (o[0]) return "R1";
      return o[1] ? "R3" : "R2";
   endfunction

   function automatic logic [31:0] corner(input int i);
      case (i)
         0: return 32'h0000_0000;
         1: return 32'h0000_0001;
         2: return 32'h0000_0002;
         3: return 32'h0000_0003;
         4: return 32'h0000_0007;
         5: return 32'h0000_000F;
         6: return 32'h0000_0010;
         7: return 32'hFFFF_FFFF;
         8: return 32'hFFFF_FFFE;
         9: return 32'h8000_0000;
         10: return 32'h8000_0001;
         11: return 32'h7FFF_FFFF;
         12: return 32'h1234_5678;
         13: return 32'hFFFF_FF9C;
         14: return 32'h0001_0000;
         default: return 32'hDEAD_BEEF;
      endcase
   endfunction

   task automatic run_op(input logic [1:0] o, input logic [31:0] x,
                         input logic [31:0] y, input bit inject);
      int n;
      bit seen, busy_ok;
      logic [31:0] exp, held;
      string t;
      exp = model(o, x, y);
      t = tag_of(o, x, y);
      @(negedge clk);
      start = 1'b1; op = o; a = x; b = y;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      n = 0; seen = 1'b0; busy_ok = 1'b1;
      while (!seen && n < 40) begin
         if (inject && (n == 3 || n == 6)) begin
            start = 1'b1; op = ~o; a = $urandom; b = $urandom;
         end else begin
            start = 1'b0;
         end
         @(posedge clk);
         n++;
         @(negedge clk);
         if (done) seen = 1'b1;
         else if (!busy) busy_ok = 1'b0;
      end
      start = 1'b0;
      chk(seen, "watchdog R8", 32'(n), 32'(o[0] ? 8 : 10));
      chk(res === exp, inject ? {t, " R9"} : t, res, exp);
      chk(busy_ok && !busy, "R8 busy", {31'b0, busy}, 32'h0);
      if (o[0]) chk(n == 8, inject ? "R6 R9" : "R6", 32'(n), 32'd8);
      else      chk(n == 10, inject ? "R7 R9" : "R7", 32'(n), 32'd10);
      held = res;
      @(posedge clk);
      @(negedge clk);
      chk(!done && res === held, "R8 pulse/hold", res, held);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && res == 0, "R8 reset", res, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && res == 0, "R8 idle", {30'b0, busy, done}, 32'h0);
      // explicit boundary cases
      run_op(2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0); // R5 quotient
      run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0); // R5 remainder
      run_op(2'b00, 32'hFFFF_FFF9, 32'h0000_0000, 1'b0); // R4 signed
      run_op(2'b11, 32'hCAFE_F00D, 32'h0000_0000, 1'b0); // R4 unsigned rem
      run_op(2'b10, 32'hFFFF_FFF9, 32'h0000_0002, 1'b0); // R3: -7 rem 2 = -1
      run_op(2'b00, 32'h0000_0007, 32'hFFFF_FFFE, 1'b1); // R2 with R9
      for (int o = 0; o < 4; o++)
         for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
               run_op(2'(o), corner(i), corner(j), ((i + j) % 5) == 0);
      for (int k = 0; k < 1500; k++) begin
         logic [31:0] x, y;
         x = $urandom;
         y = $urandom;
         if (k % 3 == 1) y = y >> (k % 29);
         if (k % 11 == 0) y = 32'($urandom_range(0, 20));
         run_op(2'($urandom_range(0, 3)), x, y, (k % 7) == 0);
      end
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule